// File: doc/BRIEF.md
# Simplex Entering Column Selector

This block examines the objective row of a simplex tableau and settles, in one pass over the row, both questions a pivot step asks first: is the tableau already optimal, and if not, which column enters the basis. A single-cycle start pulse opens a scan. After it, one signed Q16.16 coefficient is accepted on each cycle that carries a valid flag, in column order, until the parameterised row length has been consumed. Gaps between valid cycles are allowed.

The tableau is declared optimal when no accepted coefficient is below zero; zero counts as non-negative. Otherwise the reported column is the position of the most negative coefficient. A running minimum is seeded from column 0 and replaced only on a strictly smaller value, so on a tie the lowest column wins. The ratio test and the row update are left to downstream logic, which must disregard the column output while the optimal flag is set.

Top module: `ecs_entering_col`

## Requirements
- R1: After a complete scan, `optimal` is 1 exactly when none of the accepted coefficients is negative; a coefficient equal to zero counts as non-negative.
- R2: After a complete scan with at least one negative coefficient, `optimal` is 0 and `pivot_col` holds the zero-based column of the smallest coefficient.
- R3: When several columns share the smallest value, `pivot_col` reports the lowest of those columns.
- R4: Coefficients are compared as 32-bit two's-complement Q16.16 words, so a word with bit 31 set is below every word with bit 31 clear.
- R5: `done` is high for exactly one cycle, the cycle after the edge that accepts the last coefficient of the row, and once per completed scan.
- R6: A `coef_vld` cycle outside a scan (with no start pulse) is ignored: `busy` stays 0, `done` stays 0 and the outputs keep their values.
- R7: A start pulse during a scan discards the coefficients taken so far and restarts from column 0; the abandoned scan gives no `done`.
- R8: While reset is held and after its release, before any scan, `busy`, `done`, `optimal` and `pivot_col` are all 0.
- R9: `optimal` and `pivot_col` change only in a cycle where `done` is high, and hold their values until the next `done`.
- R10: `busy` is 1 from the cycle after a start pulse until the cycle after the last coefficient is accepted; cycles without `coef_vld` inside a scan do not advance the column count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that opens a new scan |
| coef_vld | input | 1 | Qualifies `coef_dat` during a scan |
| coef_dat | input | 32 | Objective coefficient, signed Q16.16 |
| busy | output | 1 | A scan is open |
| done | output | 1 | One-cycle strobe: results updated |
| optimal | output | 1 | No coefficient of the last row was negative |
| pivot_col | output | 3 | Column of the most negative coefficient |

## Verification
The bench targets ties for the minimum, where a design that compares with less-or-equal would report the last tied column instead of the first, and rows whose minimum sits in the final column, which catch an off-by-one in the last-element handling. Rows mixing large positive words with negative fractions of one least-significant bit expose an unsigned comparison, which would call such a row optimal or pick a zero column. A restart in the middle of a row and valid cycles outside any scan show whether stale partial state leaks into the result or a stray strobe appears.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_st_e;

  // Sign bit of a two's-complement word marks a negative coefficient
  function automatic logic word_is_neg(input logic msb);
    return msb;
  endfunction

endpackage

// File: rtl/ecs_rst_sync.sv
module ecs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ecs_scan_ctrl.sv
module ecs_scan_ctrl
  import ecs_pkg::*;
#(
  parameter int N_COEF = 6,
  localparam int CW = $clog2(N_COEF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          coef_vld,
  output logic          busy,
  output logic          take,
  output logic          first,
  output logic          last,
  output logic [CW-1:0] col_idx,
  output logic          done
);

  localparam logic [CW-1:0] LAST_IDX = CW'(N_COEF - 1);

  scan_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  // A coefficient is taken only inside a scan and never alongside a restart
  assign take  = (st_q == SCAN_RUN) && coef_vld && !start;
  assign first = (cnt_q == '0);
  assign last  = (cnt_q == LAST_IDX);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    done_d = 1'b0;
    if (start) begin
      st_d   = SCAN_RUN;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (take) begin
      cnt_en = 1'b1;
      if (last) begin
        st_d   = SCAN_IDLE;
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SCAN_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign busy    = (st_q == SCAN_RUN);
  assign col_idx = cnt_q;
  assign done    = done_q;

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!busy && !done));

  // R10
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt_q} < (CW+1)'(N_COEF)));

  // R10
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !coef_vld && !start) |=> ($stable(cnt_q) && busy));

endmodule

// File: rtl/ecs_min_track.sv
module ecs_min_track
  import ecs_pkg::*;
#(
  parameter int N_COEF = 6,
  parameter int COEF_W = 32,
  localparam int CW = $clog2(N_COEF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic              last,
  input  logic [CW-1:0]     col_idx,
  input  logic [COEF_W-1:0] coef,
  output logic              optimal,
  output logic [CW-1:0]     pivot_col
);

  logic signed [COEF_W-1:0] min_q, min_d;
  logic [CW-1:0]            idx_q, idx_d;
  logic                     neg_q, neg_d;
  logic                     opt_q, opt_d;
  logic [CW-1:0]            col_q, col_d;
  logic                     run_en;
  logic                     res_en;
  logic                     new_min;

  // Strictly smaller replaces; column 0 always seeds the running minimum
  always_comb begin
    new_min = first || ($signed(coef) < min_q);
    run_en  = take;
    res_en  = take && last;
    min_d   = new_min ? $signed(coef) : min_q;
    idx_d   = new_min ? col_idx : idx_q;
    neg_d   = (first ? 1'b0 : neg_q) | word_is_neg(coef[COEF_W-1]);
    opt_d   = !neg_d;
    col_d   = idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= '0;
      idx_q <= '0;
      neg_q <= 1'b0;
    end else if (run_en) begin
      min_q <= min_d;
      idx_q <= idx_d;
      neg_q <= neg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q <= 1'b0;
      col_q <= '0;
    end else if (res_en) begin
      opt_q <= opt_d;
      col_q <= col_d;
    end
  end

  assign optimal   = opt_q;
  assign pivot_col = col_q;

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && last) |=> ($stable(opt_q) && $stable(col_q)));

  // R2
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, col_q} < (CW+1)'(N_COEF)));

  // R3
  tie_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !first && ($signed(coef) == min_q)) |=> $stable(idx_q));

  // R1
  opt_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !first && neg_q) |=> neg_q);

endmodule

// File: rtl/ecs_entering_col.sv
module ecs_entering_col
  import ecs_pkg::*;
#(
  parameter int N_COEF = 6,
  parameter int COEF_W = 32,
  localparam int CW = $clog2(N_COEF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              coef_vld,
  input  logic [COEF_W-1:0] coef_dat,
  output logic              busy,
  output logic              done,
  output logic              optimal,
  output logic [CW-1:0]     pivot_col
);

  logic          rst_n_i;
  logic          take;
  logic          first;
  logic          last;
  logic [CW-1:0] col_idx;

  ecs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  ecs_scan_ctrl #(.N_COEF(N_COEF)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .start    (start),
    .coef_vld (coef_vld),
    .busy     (busy),
    .take     (take),
    .first    (first),
    .last     (last),
    .col_idx  (col_idx),
    .done     (done)
  );

  ecs_min_track #(.N_COEF(N_COEF), .COEF_W(COEF_W)) u_min (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .take      (take),
    .first     (first),
    .last      (last),
    .col_idx   (col_idx),
    .coef      (coef_dat),
    .optimal   (optimal),
    .pivot_col (pivot_col)
  );

  // R9
  out_change_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!$stable(pivot_col) || !$stable(optimal)) |-> done);

endmodule

// File: tb/sim_ecs_entering_col.sv
module sim_ecs_entering_col;

  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        coef_vld;
  logic [31:0] coef_dat;
  logic        busy;
  logic        done;
  logic        optimal;
  logic [2:0]  pivot_col;

  int checks;
  int fails;
  int dones_seen;
  int scans_pushed;
  bit finished;

  bit    exp_opt[$];
  int    exp_col[$];
  string exp_tag[$];

  ecs_entering_col u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .coef_vld  (coef_vld),
    .coef_dat  (coef_dat),
    .busy      (busy),
    .done      (done),
    .optimal   (optimal),
    .pivot_col (pivot_col)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int q16(input int v);
    return v * 65536;
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Driver: computes the expected outcome and pushes it, then feeds the row
  task automatic run_scan(input int row[N], input int gap, input string tag);
    int mn;
    int mi;
    bit neg;
    mn  = row[0];
    mi  = 0;
    neg = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (row[i] < 0) neg = 1'b1;
      if (row[i] < mn) begin
        mn = row[i];
        mi = i;
      end
    end
    exp_opt.push_back(!neg);
    exp_col.push_back(mi);
    exp_tag.push_back(tag);
    scans_pushed++;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 busy after start", busy == 1'b1, int'(busy), 1);
    for (int i = 0; i < N; i++) begin
      for (int g = 0; g < gap; g++) begin
        coef_vld = 1'b0;
        @(negedge clk);
      end
      coef_vld = 1'b1;
      coef_dat = row[i];
      @(negedge clk);
    end
    coef_vld = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pops and compares on each done strobe
  always @(negedge clk) begin
    if (rst_n && done) begin
      dones_seen++;
      if (exp_opt.size() == 0) begin
        check("R5 unexpected done", 1'b0, 1, 0);
      end else begin
        bit    eo;
        int    ec;
        string et;
        eo = exp_opt.pop_front();
        ec = exp_col.pop_front();
        et = exp_tag.pop_front();
        check({et, " optimal (R1)"}, optimal == eo, int'(optimal), int'(eo));
        if (!eo) begin
          check({et, " pivot_col (R2)"}, int'(pivot_col) == ec, int'(pivot_col), ec);
        end
        check("R10 busy low at done", busy == 1'b0, int'(busy), 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int row[N];
    int hold_col;
    bit hold_opt;
    int d0;
    checks = 0; fails = 0; dones_seen = 0; scans_pushed = 0; finished = 0;
    rst_n = 1'b0; start = 1'b0; coef_vld = 1'b0; coef_dat = '0;
    repeat (3) @(negedge clk);
    // R8 reset state while reset held
    check("R8 busy in reset", busy == 1'b0, int'(busy), 0);
    check("R8 done in reset", done == 1'b0, int'(done), 0);
    check("R8 optimal in reset", optimal == 1'b0, int'(optimal), 0);
    check("R8 pivot_col in reset", pivot_col == 3'd0, int'(pivot_col), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 busy after release", busy == 1'b0, int'(busy), 0);
    check("R8 pivot_col after release", pivot_col == 3'd0, int'(pivot_col), 0);

    // R2 canonical objective row
    row = '{q16(-6), q16(-5), q16(-4), 0, 0, 0};
    run_scan(row, 0, "R2 base");
    // R1 zeros and positives only
    row = '{0, q16(3), 0, q16(1), 0, 1};
    run_scan(row, 0, "R1 nonneg");
    // R1 all zero
    row = '{0, 0, 0, 0, 0, 0};
    run_scan(row, 1, "R1 zeros");
    // R3 tie on the minimum
    row = '{q16(3), q16(-2), q16(5), q16(-2), q16(1), q16(-2)};
    run_scan(row, 0, "R3 tie");
    // R3 tie including column 0
    row = '{q16(-7), q16(2), q16(-7), 0, q16(-1), q16(-7)};
    run_scan(row, 2, "R3 tie col0");
    // R2 minimum in final column, with gaps (R10)
    row = '{q16(1), q16(2), q16(3), q16(4), q16(5), q16(-1)};
    run_scan(row, 3, "R2 last col R10");
    // R4 signed ordering: bit-31 words below large positives
    row = '{32'h7FFF0000, 1, -1, 0, 32'h40000000, -1};
    run_scan(row, 0, "R4 signed");
    // R4 single tiny negative fraction
    row = '{32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, -1, 32'h00010000, 0};
    run_scan(row, 0, "R4 tiny neg");

    // R7 restart mid-scan: abandoned prefix is all negative
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      coef_vld = 1'b1;
      coef_dat = q16(-9);
      @(negedge clk);
    end
    coef_vld = 1'b0;
    d0 = dones_seen;
    row = '{q16(2), q16(4), 0, q16(1), q16(8), q16(6)};
    run_scan(row, 0, "R7 restart");
    check("R7 one done for restarted scan", dones_seen == d0 + 1, dones_seen - d0, 1);

    // R6 and R9: valid outside a scan is ignored, results hold
    hold_opt = optimal;
    hold_col = int'(pivot_col);
    d0 = dones_seen;
    for (int i = 0; i < 6; i++) begin
      coef_vld = 1'b1;
      coef_dat = q16(-3 - i);
      @(negedge clk);
      check("R6 busy stays low", busy == 1'b0, int'(busy), 0);
      check("R9 optimal held", optimal == hold_opt, int'(optimal), int'(hold_opt));
      check("R9 pivot_col held", int'(pivot_col) == hold_col, int'(pivot_col), hold_col);
    end
    coef_vld = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 no done from stray valid", dones_seen == d0, dones_seen - d0, 0);

    // R5 one strobe per completed scan, nothing left queued
    check("R5 done count", dones_seen == scans_pushed, dones_seen, scans_pushed);
    check("R5 queue drained", exp_opt.size() == 0, exp_opt.size(), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule